// File: doc/BRIEF.md
# Masked edge-capture interrupt controller

This block collects interrupt requests from a small set of external lines and merges them into one active-low interrupt pin. Every request line first passes through a synchroniser. A rising transition on a line then latches a sticky status bit. A status bit stays set until a command engine clears it with a bitwise clear byte. A separate enable mask chooses which latched bits may assert the interrupt pin. The command engine can read back both the status register and the enable register as 8-bit values.

The block does not decode any bus protocol. The command engine that sits in front of it supplies three things: a one-cycle write-enable strobe, a one-cycle clear strobe and the data byte that goes with them. The pin stage works in one of two modes, picked at build time. In push-pull mode the pin is always driven. In open-drain mode the pin only ever pulls low, through an output-enable.

Top module: `edge_irq_top`

## Requirements
- R1: After reset, the status readback and the enable readback are both 0x00, and the interrupt is inactive.
- R2: A 0-to-1 transition on request line i sets status bit i. If the line is applied before clock edge k, the bit shows on the status readback after edge k+2 (two synchroniser flops plus the status register). The edge detector produces a pulse that lasts one cycle.
- R3: A line held high sets its bit only once. After a clear, the bit stays 0 until the line goes low and rises again.
- R4: With the clear strobe high, each 1 in data bits [NUM_IRQ-1:0] clears the matching status bit at the next edge. Each 0 leaves its bit unchanged.
- R5: When a new edge on line i reaches the status register in the same cycle as a clear of bit i, the bit ends up set.
- R6: With the enable-write strobe high, data bits [NUM_IRQ-1:0] load the enable register at the next edge. The enable readback returns that value.
- R7: Readback bits from NUM_IRQ up to 7 are always 0 in both registers.
- R8: The interrupt is active whenever, for some i, status bit i and enable bit i are both 1. It follows the registers in the same cycle.
- R9: In push-pull mode (OPEN_DRAIN=0) the output enable is always 1, and the pin level is the inverse of the active flag. In open-drain mode (OPEN_DRAIN=1) the pin level is always 0, and the output enable equals the active flag.
- R10: An enable write leaves the status register unchanged. A clear leaves the enable register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | NUM_IRQ | Raw request lines, asynchronous to clk |
| enWrStb | input | 1 | Loads the enable register from wrData |
| clrStb | input | 1 | Clears status bits where wrData has a 1 |
| wrData | input | 8 | Data byte from the command engine |
| statusRd | output | 8 | Status register readback |
| enableRd | output | 8 | Enable register readback |
| intqOut | output | 1 | Interrupt pin level (active low) |
| intqOe | output | 1 | Interrupt pin output enable |

## Verification
The bench builds two copies with NUM_IRQ=4 and two synchroniser stages, one copy in each pin mode. Both copies get the same stimulus, so the push-pull and open-drain encodings of the same active flag are compared side by side. With four lines, the data bytes can carry 1s in the reserved bit positions 7:4, which shows that those bits are neither stored nor returned. A set and a clear of the same bit can also be arranged to land in one cycle.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int REG_W = 8;

  // strobes handed from control to datapath
  typedef struct packed {
    logic loadEn;
    logic doClear;
  } irq_stb_t;
endpackage

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int NUM_IRQ     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               enWrStb,
  input  logic               clrStb,
  output logic [NUM_IRQ-1:0] riseEdge,
  output irq_stb_t           stb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NUM_IRQ-1:0] syncQ;
  logic [NUM_IRQ-1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], irqIn};
      prevQ <= syncQ[LAST];
    end
  end

  always_comb begin
    riseEdge    = syncQ[LAST] & ~prevQ;
    stb.loadEn  = enWrStb;
    stb.doClear = clrStb;
  end

  // a rise pulse never lasts two cycles
  assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|riseEdge) |=> ((riseEdge & $past(riseEdge)) == '0));
endmodule

// File: rtl/edge_irq_dp.sv
module edge_irq_dp
  import edge_irq_pkg::*;
#(
  parameter int NUM_IRQ    = 4,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] riseEdge,
  input  irq_stb_t           stb,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   statusRd,
  output logic [REG_W-1:0]   enableRd,
  output logic               intqOut,
  output logic               intqOe
);
  localparam int PAD = REG_W - NUM_IRQ;

  logic [NUM_IRQ-1:0] statusQ, enableQ, clrMask;
  logic active;

  assign clrMask = stb.doClear ? wrData[NUM_IRQ-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= (statusQ & ~clrMask) | riseEdge;
      if (stb.loadEn) enableQ <= wrData[NUM_IRQ-1:0];
    end
  end

  generate
    if (PAD > 0) begin : g_pad
      assign statusRd = {{PAD{1'b0}}, statusQ};
      assign enableRd = {{PAD{1'b0}}, enableQ};
    end else begin : g_nopad
      assign statusRd = statusQ;
      assign enableRd = enableQ;
    end
  endgenerate

  assign active = |(statusQ & enableQ);

  generate
    if (OPEN_DRAIN) begin : g_od
      assign intqOut = 1'b0;
      assign intqOe  = active;
    end else begin : g_pp
      assign intqOut = ~active;
      assign intqOe  = 1'b1;
    end
  endgenerate

  assert_enable_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadEn |=> enableQ == $past(wrData[NUM_IRQ-1:0]));

  assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|riseEdge) |=> ((statusQ & $past(riseEdge)) == $past(riseEdge)));

  assert_clear_applies_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doClear && riseEdge == '0) |=> ((statusQ & $past(wrData[NUM_IRQ-1:0])) == '0));

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.doClear && riseEdge == '0) |=> $stable(statusQ));

  assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadEn |=> $stable(enableQ));
endmodule

// File: rtl/edge_irq_top.sv
module edge_irq_top
  import edge_irq_pkg::*;
#(
  parameter int NUM_IRQ     = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit OPEN_DRAIN  = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               enWrStb,
  input  logic               clrStb,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   statusRd,
  output logic [REG_W-1:0]   enableRd,
  output logic               intqOut,
  output logic               intqOe
);
  logic [NUM_IRQ-1:0] riseEdge;
  irq_stb_t stb;

  edge_irq_ctrl #(.NUM_IRQ(NUM_IRQ), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .enWrStb(enWrStb),
    .clrStb(clrStb), .riseEdge(riseEdge), .stb(stb));

  edge_irq_dp #(.NUM_IRQ(NUM_IRQ), .OPEN_DRAIN(OPEN_DRAIN)) dp_i (
    .clk(clk), .rstN(rstN), .riseEdge(riseEdge), .stb(stb), .wrData(wrData),
    .statusRd(statusRd), .enableRd(enableRd), .intqOut(intqOut), .intqOe(intqOe));
endmodule

// File: tb/edge_irq_top_tb_top.sv
module edge_irq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 0;
  logic rstN = 0;
  logic [N-1:0] irq = '0;
  logic enWr = 0, clr = 0;
  logic [7:0] wrData = '0;
  logic [7:0] stPp, enPp, stOd, enOd;
  logic outPp, oePp, outOd, oeOd;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // behavioural model
  int hist[$];
  int mStatus = 0, mEnable = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_top #(.NUM_IRQ(N), .SYNC_STAGES(2), .OPEN_DRAIN(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irq), .enWrStb(enWr), .clrStb(clr),
    .wrData(wrData), .statusRd(stPp), .enableRd(enPp), .intqOut(outPp), .intqOe(oePp));

  edge_irq_top #(.NUM_IRQ(N), .SYNC_STAGES(2), .OPEN_DRAIN(1'b1)) dut_od_i (
    .clk(clk), .rstN(rstN), .irqIn(irq), .enWrStb(enWr), .clrStb(clr),
    .wrData(wrData), .statusRd(stOd), .enableRd(enOd), .intqOut(outOd), .intqOe(oeOd));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // model update at each edge, out of reset
  always @(posedge clk) begin
    if (rstN) begin
      int edgeV, clrM;
      edgeV = hist[1] & ~hist[2] & 'hF;
      clrM = clr ? (wrData & 'hF) : 0;
      mStatus = (mStatus & ~clrM) | edgeV;
      if (enWr) mEnable = wrData & 'hF;
      hist.push_front(int'(irq));
      void'(hist.pop_back());
    end
  end

  // compare each cycle away from the edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <5000 cycles", cycles);
      finishRun();
    end
    if (rstN) begin
      int act;
      act = ((mStatus & mEnable) != 0) ? 1 : 0;
      check("R2/R3/R4/R5 status", stPp, mStatus);
      check("R6/R7/R10 enable", enPp, mEnable);
      check("R8/R9 push-pull level", outPp, act ? 0 : 1);
      check("R9 push-pull oe", oePp, 1);
      check("R2 open-drain status", stOd, mStatus);
      check("R9 open-drain level", outOd, 0);
      check("R8/R9 open-drain oe", oeOd, act);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(bit w, bit c, logic [7:0] d);
    enWr = w; clr = c; wrData = d;
    cyc();
    enWr = 0; clr = 0; wrData = '0;
  endtask

  initial begin
    hist = {0, 0, 0};
    cyc(3);
    rstN = 1;
    cyc();
    check("R1 status reset", stPp, 0);
    check("R1 enable reset", enPp, 0);
    check("R1 pin inactive", outPp, 1);

    // R2: rise on line 0, visible after third edge
    irq = 4'b0001;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R2 not yet visible", stPp, 0);
    @(posedge clk); #1;
    check("R2 status bit0 set", stPp, 8'h01);
    cyc();
    check("R8 masked: pin inactive", outPp, 1);

    // R6/R7: enable write, reserved bits dropped
    cmd(1, 0, 8'hF1);
    check("R7 enable reserved zero", enPp, 8'h01);
    check("R8 pin active", outPp, 0);
    check("R10 status kept on enable write", stPp, 8'h01);

    // R3: held high, clear, no re-set
    cmd(0, 1, 8'hF1);
    check("R4 bit0 cleared", stPp, 0);
    check("R10 enable kept on clear", enPp, 8'h01);
    cyc(6);
    check("R3 held level no re-set", stPp, 0);
    irq = 4'b0000; cyc(4);
    irq = 4'b0001; cyc(4);
    check("R3 new rise sets again", stPp, 8'h01);

    // R4: partial clear
    irq = 4'b1111; cyc(4);
    check("R2 all lines", stPp, 8'h0F);
    cmd(0, 1, 8'b0000_0101);
    check("R4 partial clear", stPp, 8'h0A);

    // R5: edge on line 0 arrives with its clear; irq0 low then high
    irq = 4'b1110; cyc(4);
    cmd(0, 1, 8'h01);
    irq = 4'b1111;           // applied before edge k
    @(posedge clk); #1;      // edge k
    clr = 1; wrData = 8'h01; // clear at edge k+2 alongside edge pulse
    @(posedge clk); #1;      // edge k+1
    @(negedge clk);
    @(posedge clk); #1;      // edge k+2
    clr = 0; wrData = 0;
    cyc();
    check("R5 set wins over clear", stPp & 8'h01, 8'h01);

    // random-ish patterns compared by the model
    for (int i = 0; i < 200; i++) begin
      irq = N'((i * 7 + i / 3) ^ (i >> 2));
      if (i % 11 == 3) cmd(1, 0, 8'(i * 37));
      else if (i % 7 == 5) cmd(0, 1, 8'(i * 13));
      else if (i % 17 == 9) cmd(1, 1, 8'(i * 29));
      else cyc();
    end

    cmd(1, 0, 8'h00);
    check("R8 disabled pin inactive", outPp, 1);
    check("R9 open-drain oe off", oeOd, 0);
    cyc(2);
    finishRun();
  end
endmodule